// File: doc/BRIEF.md
# Packed Subword Fixed-Point Lane ALU

This block is a single 64-bit datapath lane that treats its operand word as a packed group of integer elements. Each operation chooses how to slice the word: one 64-bit element, two 32-bit elements or four 16-bit elements. Within that slicing every element is processed on its own. The lane supports addition, subtraction, logical left and right shifts, and an arithmetic right shift with an optional round-half-up step. It also has a fixed-point multiply-accumulate that multiplies the low halves of two elements and adds the product into a full-width accumulator.

Additions, subtractions and multiply-accumulates can clamp to the element range instead of wrapping. Each element then reports whether it clamped. The second operand can be replaced by a scalar whose low bits are copied to every element. A per-element flag mask decides which elements are written; the others return the previous destination contents.

The lane is meant to be replicated beside others in a wider vector unit. The caller supplies the old destination word, which also acts as the accumulator. The result comes back one clock later with a matching valid strobe.

Top module: `lane_alu`

## Requirements
- R1: The width code selects the element slicing. Code 0 gives four 16-bit elements, code 1 gives two 32-bit elements, and codes 2 and 3 give one 64-bit element. Element i occupies bits [i*W+W-1 : i*W]. No carry, borrow or sign bit crosses from one element into the next.
- R2: Opcode 0 adds and opcode 1 subtracts (a minus b) per element. With saturation disabled, the result wraps modulo 2^W and every saturation flag is 0.
- R3: With saturation enabled (opcodes 0, 1 and 5), an out-of-range result is clamped and that element's flag is set. In signed mode the clamp goes to the most negative or most positive two's-complement value. In unsigned mode an add clamps to all ones and a subtract clamps to 0.
- R4: Opcode 2 shifts left and opcode 3 shifts right logically. The shift amount is the low 6 bits of the element's b operand, and an amount of W or more gives 0. Shifts never set a saturation flag.
- R5: Opcode 4 shifts right arithmetically by the low 6 bits of b. With rounding off it truncates toward minus infinity. With rounding on, 2^(amount-1) is added before the shift when the amount is non-zero. For an amount of W or more the result is the sign fill when truncating and 0 when rounding. The signed-mode bit has no effect on this opcode.
- R6: Opcode 5 multiplies the low W/2 bits of a and b, treating them as signed or unsigned according to the signed-mode bit. It adds the W-bit product to the element of the old destination word, applying the add saturation rules of R3.
- R7: When the scalar select is high, the low W bits of the scalar input replace the b operand of every element, and b is ignored.
- R8: Element i is written only when mask bit i is 1. A masked-off element returns the old destination element and its saturation flag is 0. Flags above the element count are 0.
- R9: Result and flags are registered. out_valid follows in_valid by one clock, and the outputs hold while in_valid is low. Reset clears the result, the flags and out_valid.
- R10: Opcodes 6 and 7 are reserved. They return the old destination word and clear all saturation flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation select (R2 to R6, R10) |
| width_sel | input | 2 | Element width code (R1) |
| signed_mode | input | 1 | Signed interpretation for saturation and multiply |
| sat_en | input | 1 | Enable clamping |
| round_en | input | 1 | Round-half-up for arithmetic right shift |
| scalar_sel | input | 1 | Replace b with broadcast scalar |
| elem_mask | input | 4 | Per-element write enable |
| src_a | input | 64 | First operand word |
| src_b | input | 64 | Second operand word |
| scalar_in | input | 64 | Scalar operand |
| old_dst | input | 64 | Previous destination word and accumulator |
| out_valid | output | 1 | Result strobe |
| result | output | 64 | Packed result word |
| sat_flags | output | 4 | Per-element clamp indicators |

## Verification
The hardest case to reach is a single word in which some elements hit the positive rail, another hits the negative rail, and another stays in range. The stimulus for it has to be chosen per element. The bench builds such words and then repeats them with the mask removing clamping elements, to show that the flags vanish along with the writes. Rounding at shift amounts of W and above is also hard to reach, because it needs a 6-bit amount larger than a 16-bit element. The bench places such an amount in one element next to small amounts in the others.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;
   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_SLL  = 3'd2,
      OP_SRL  = 3'd3,
      OP_SRA  = 3'd4,
      OP_MAC  = 3'd5,
      OP_RSV6 = 3'd6,
      OP_RSV7 = 3'd7
   } lane_op_e;

   typedef struct packed {
      logic sgn;
      logic sat;
      logic rnd;
   } lane_mode_t;
endpackage

// File: rtl/lane_alu_elem.sv
module lane_alu_elem
   import lane_alu_pkg::*;
#(
   parameter int EW   = 16,
   parameter int SH_W = 6
) (
   input  lane_op_e         op,
   input  lane_mode_t       mode,
   input  logic [EW-1:0]    a,
   input  logic [EW-1:0]    b,
   input  logic [EW-1:0]    acc,
   output logic [EW-1:0]    res,
   output logic             sat
);
   localparam int HW = EW / 2;
   localparam int XW = EW + 1;

   initial begin : elab_chk
      if (EW % 2 != 0) $error("lane_alu_elem: EW must be even");
      if (EW < SH_W)   $error("lane_alu_elem: EW must hold a shift amount");
   end

   logic signed [XW-1:0] ext_a, ext_b, ext_acc, ext_p, sum_x;
   logic signed [XW-1:0] sra_x, sra_r, sra_q, rnd_add;
   logic [EW-1:0]        mul_a, mul_b, prod, clamp;
   logic [SH_W-1:0]      sh;
   logic                 big, ovf, arith;

   always_comb begin
      ext_a   = {mode.sgn & a[EW-1], a};
      ext_b   = {mode.sgn & b[EW-1], b};
      ext_acc = {mode.sgn & acc[EW-1], acc};
      mul_a   = mode.sgn ? {{HW{a[HW-1]}}, a[HW-1:0]} : {{HW{1'b0}}, a[HW-1:0]};
      mul_b   = mode.sgn ? {{HW{b[HW-1]}}, b[HW-1:0]} : {{HW{1'b0}}, b[HW-1:0]};
      prod    = mul_a * mul_b;
      ext_p   = {mode.sgn & prod[EW-1], prod};

      unique case (op)
         OP_SUB:  sum_x = ext_a - ext_b;
         OP_MAC:  sum_x = ext_acc + ext_p;
         default: sum_x = ext_a + ext_b;
      endcase

      arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_MAC);
      if (mode.sgn) begin
         ovf   = sum_x[EW] != sum_x[EW-1];
         clamp = sum_x[EW] ? {1'b1, {(EW-1){1'b0}}} : {1'b0, {(EW-1){1'b1}}};
      end else begin
         ovf   = sum_x[EW];
         clamp = (op == OP_SUB) ? '0 : '1;
      end

      sh      = b[SH_W-1:0];
      big     = ({1'b0, sh} >= (SH_W+1)'(EW));
      sra_x   = {a[EW-1], a};
      rnd_add = (mode.rnd && (sh != '0) && !big) ? (XW'(1) << (sh - 1'b1)) : '0;
      sra_r   = sra_x + rnd_add;
      sra_q   = sra_r >>> sh;

      sat = 1'b0;
      unique case (op)
         OP_ADD, OP_SUB, OP_MAC: begin
            sat = arith && mode.sat && ovf;
            res = sat ? clamp : sum_x[EW-1:0];
         end
         OP_SLL:  res = big ? '0 : (a << sh);
         OP_SRL:  res = big ? '0 : (a >> sh);
         OP_SRA:  res = big ? (mode.rnd ? '0 : {EW{a[EW-1]}}) : sra_q[EW-1:0];
         default: res = acc;
      endcase
   end
endmodule

// File: rtl/lane_alu_wb.sv
module lane_alu_wb #(
   parameter int LANE_W = 64,
   parameter int MIN_W  = 16,
   parameter int NSLOT  = LANE_W / MIN_W,
   parameter int WSEL_W = 2
) (
   input  logic [WSEL_W-1:0] wsel,
   input  logic [NSLOT-1:0]  mask,
   input  logic [LANE_W-1:0] res_in,
   input  logic [NSLOT-1:0]  sat_in,
   input  logic [LANE_W-1:0] old_dst,
   output logic [LANE_W-1:0] wb_res,
   output logic [NSLOT-1:0]  wb_sat
);
   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      logic wr_en, live;
      assign wr_en = mask[s >> wsel];
      assign live  = s < (NSLOT >> wsel);
      assign wb_res[s*MIN_W +: MIN_W] = wr_en ? res_in[s*MIN_W +: MIN_W]
                                               : old_dst[s*MIN_W +: MIN_W];
      assign wb_sat[s] = sat_in[s] & mask[s] & live;
   end
endmodule

// File: rtl/lane_alu.sv
module lane_alu
   import lane_alu_pkg::*;
#(
   parameter int LANE_W = 64,
   parameter int MIN_W  = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic [2:0]  op_code,
   input  logic [1:0]  width_sel,
   input  logic        signed_mode,
   input  logic        sat_en,
   input  logic        round_en,
   input  logic        scalar_sel,
   input  logic [3:0]  elem_mask,
   input  logic [63:0] src_a,
   input  logic [63:0] src_b,
   input  logic [63:0] scalar_in,
   input  logic [63:0] old_dst,
   output logic        out_valid,
   output logic [63:0] result,
   output logic [3:0]  sat_flags
);
   localparam int NSLOT  = LANE_W / MIN_W;
   localparam int NWID   = $clog2(NSLOT) + 1;
   localparam int WSEL_W = (NWID > 1) ? $clog2(NWID) : 1;
   localparam int SH_W   = $clog2(LANE_W);

   initial begin : elab_chk
      if (LANE_W % MIN_W != 0)         $error("lane_alu: LANE_W must be a multiple of MIN_W");
      if ((NSLOT & (NSLOT - 1)) != 0)  $error("lane_alu: slot count must be a power of two");
      if (NSLOT != 4 || LANE_W != 64)  $error("lane_alu: port widths assume 64-bit lane, 16-bit minimum");
      if (WSEL_W > 2)                  $error("lane_alu: width code too wide for port");
   end

   lane_op_e         op_e;
   lane_mode_t       mode;
   logic [WSEL_W-1:0] wsel_eff;
   logic [LANE_W-1:0] res_w [NWID];
   logic [NSLOT-1:0]  sat_w [NWID];
   logic [LANE_W-1:0] res_sel, wb_res;
   logic [NSLOT-1:0]  sat_sel, wb_sat;

   assign op_e     = lane_op_e'(op_code);
   assign mode     = '{sgn: signed_mode, sat: sat_en, rnd: round_en};
   assign wsel_eff = (int'(width_sel) >= NWID) ? WSEL_W'(NWID - 1) : width_sel[WSEL_W-1:0];

   for (genvar gw = 0; gw < NWID; gw++) begin : g_width
      localparam int EW = MIN_W << gw;
      localparam int NE = NSLOT >> gw;
      logic [LANE_W-1:0] res_loc;
      logic [NSLOT-1:0]  sat_loc;

      for (genvar e = 0; e < NE; e++) begin : g_elem
         logic [EW-1:0] b_op;
         assign b_op = scalar_sel ? scalar_in[EW-1:0] : src_b[e*EW +: EW];
         lane_alu_elem #(.EW(EW), .SH_W(SH_W)) elem_i (
            .op   (op_e),
            .mode (mode),
            .a    (src_a[e*EW +: EW]),
            .b    (b_op),
            .acc  (old_dst[e*EW +: EW]),
            .res  (res_loc[e*EW +: EW]),
            .sat  (sat_loc[e])
         );
      end
      if (NE < NSLOT) begin : g_pad
         assign sat_loc[NSLOT-1:NE] = '0;
      end
      assign res_w[gw] = res_loc;
      assign sat_w[gw] = sat_loc;
   end

   assign res_sel = res_w[wsel_eff];
   assign sat_sel = sat_w[wsel_eff];

   lane_alu_wb #(.LANE_W(LANE_W), .MIN_W(MIN_W), .NSLOT(NSLOT), .WSEL_W(WSEL_W)) wb_i (
      .wsel    (wsel_eff),
      .mask    (elem_mask),
      .res_in  (res_sel),
      .sat_in  (sat_sel),
      .old_dst (old_dst),
      .wb_res  (wb_res),
      .wb_sat  (wb_sat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         sat_flags <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result    <= wb_res;
            sat_flags <= wb_sat;
         end
      end
   end

   AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R9
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> (!out_valid && $stable(result) && $stable(sat_flags))); // R9
   AST_SAT_MASKED: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> ((sat_flags & ~$past(elem_mask)) == '0)); // R8
   AST_KEEP_SLOT0: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !elem_mask[0]) |=> (result[MIN_W-1:0] == $past(old_dst[MIN_W-1:0]))); // R8
   AST_SHIFT_NO_SAT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && (op_code == 3'd2 || op_code == 3'd3 || op_code == 3'd4)) |=> (sat_flags == '0)); // R4
   AST_RSV_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && op_code[2] && op_code[1]) |=> (result == $past(old_dst) && sat_flags == '0)); // R10
   AST_SIGNED_RAIL: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && width_sel == 2'd0 && signed_mode) |=> (!sat_flags[0] || result[15:0] == 16'h7FFF || result[15:0] == 16'h8000)); // R3
endmodule

// File: tb/lane_alu_tb_top.sv
module lane_alu_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  op_code = '0;
   logic [1:0]  width_sel = '0;
   logic        signed_mode = 1'b0, sat_en = 1'b0, round_en = 1'b0, scalar_sel = 1'b0;
   logic [3:0]  elem_mask = '0;
   logic [63:0] src_a = '0, src_b = '0, scalar_in = '0, old_dst = '0;
   logic        out_valid;
   logic [63:0] result;
   logic [3:0]  sat_flags;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lane_alu dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
      .width_sel(width_sel), .signed_mode(signed_mode), .sat_en(sat_en),
      .round_en(round_en), .scalar_sel(scalar_sel), .elem_mask(elem_mask),
      .src_a(src_a), .src_b(src_b), .scalar_in(scalar_in), .old_dst(old_dst),
      .out_valid(out_valid), .result(result), .sat_flags(sat_flags)
   );

   task automatic drive(input logic [2:0] op, input logic [1:0] w, input logic sg,
                        input logic st, input logic rd, input logic vs, input logic [3:0] m,
                        input logic [63:0] a, input logic [63:0] b, input logic [63:0] s,
                        input logic [63:0] d);
      @(negedge clk);
      op_code = op; width_sel = w; signed_mode = sg; sat_en = st; round_en = rd;
      scalar_sel = vs; elem_mask = m; src_a = a; src_b = b; scalar_in = s; old_dst = d;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic expect_out(input string tag, input logic [63:0] er, input logic [3:0] es);
      checks++;
      if (result !== er || sat_flags !== es || out_valid !== 1'b1) begin
         failures++;
         $display("FAIL %s actual result=%h sat=%b valid=%b expected result=%h sat=%b valid=1",
                  tag, result, sat_flags, out_valid, er, es);
      end
   endtask

   task automatic t_reset();
      checks++;
      if (result !== 64'h0 || sat_flags !== 4'h0 || out_valid !== 1'b0) begin
         failures++;
         $display("FAIL R9 reset actual result=%h sat=%b valid=%b expected 0 0 0", result, sat_flags, out_valid);
      end
   endtask

   task automatic t_widths();
      drive(3'd0, 2'd0, 1, 0, 0, 0, 4'hF, 64'h0001_FFFF_7FFF_1234, 64'h0001_0001_0001_0001, 0, 0);
      expect_out("R1 R2 add16 wrap", 64'h0002_0000_8000_1235, 4'b0000);
      drive(3'd0, 2'd0, 0, 0, 0, 0, 4'hF, 64'h0000_0000_FFFF_FFFF, 64'h1, 0, 0);
      expect_out("R1 add16 carry stop", 64'h0000_0000_FFFF_0000, 4'b0000);
      drive(3'd0, 2'd1, 0, 0, 0, 0, 4'hF, 64'h0000_0000_FFFF_FFFF, 64'h1, 0, 0);
      expect_out("R1 add32 carry stop", 64'h0, 4'b0000);
      drive(3'd0, 2'd2, 0, 0, 0, 0, 4'hF, 64'h0000_0000_FFFF_FFFF, 64'h1, 0, 0);
      expect_out("R1 add64 carry crosses", 64'h0000_0001_0000_0000, 4'b0000);
      drive(3'd0, 2'd3, 0, 0, 0, 0, 4'hF, 64'h0000_0000_FFFF_FFFF, 64'h1, 0, 0);
      expect_out("R1 code3 is 64-bit", 64'h0000_0001_0000_0000, 4'b0000);
      drive(3'd1, 2'd0, 1, 0, 0, 0, 4'hF, 64'h0, 64'h1, 0, 0);
      expect_out("R2 sub16 wrap no borrow", 64'h0000_0000_0000_FFFF, 4'b0000);
   endtask

   task automatic t_saturate();
      drive(3'd1, 2'd0, 0, 1, 0, 0, 4'hF, 64'h0005_0003_FFFF_0000, 64'h0003_0005_0001_0001, 0, 0);
      expect_out("R3 unsigned sub clamp", 64'h0002_0000_FFFE_0000, 4'b0101);
      drive(3'd0, 2'd0, 1, 1, 0, 0, 4'hF, 64'h7FFF_8000_0010_7000, 64'h0001_FFFF_FFF0_1000, 0, 0);
      expect_out("R3 signed add clamp", 64'h7FFF_8000_0000_7FFF, 4'b1101);
      drive(3'd0, 2'd1, 0, 1, 0, 0, 4'hF, 64'hFFFF_FFF0_0000_0001, 64'h0000_0020_0000_0002, 0, 0);
      expect_out("R3 unsigned add32 clamp", 64'hFFFF_FFFF_0000_0003, 4'b0010);
   endtask

   task automatic t_logic_shift();
      drive(3'd2, 2'd0, 0, 1, 0, 0, 4'hF, 64'h8001_00FF_1234_0001, 64'h0001_0008_0010_0044, 0, 0);
      expect_out("R4 sll16", 64'h0002_FF00_0000_0010, 4'b0000);
      drive(3'd3, 2'd1, 0, 1, 0, 0, 4'hF, 64'h8000_0000_0000_F000, 64'h0000_001F_0000_0004, 0, 0);
      expect_out("R4 srl32", 64'h0000_0001_0000_0F00, 4'b0000);
   endtask

   task automatic t_arith_shift();
      drive(3'd4, 2'd0, 0, 0, 0, 0, 4'hF, 64'hFFFB_0005_8000_FFFF, 64'h0001_0001_0014_0001, 0, 0);
      expect_out("R5 sra16 truncate", 64'hFFFD_0002_FFFF_FFFF, 4'b0000);
      drive(3'd4, 2'd0, 1, 0, 1, 0, 4'hF, 64'hFFFB_0005_8000_FFFF, 64'h0001_0001_0014_0001, 0, 0);
      expect_out("R5 sra16 round", 64'hFFFE_0003_0000_0000, 4'b0000);
      drive(3'd4, 2'd2, 0, 0, 0, 0, 4'hF, 64'd23, 64'd3, 0, 0);
      expect_out("R5 sra64 truncate", 64'd2, 4'b0000);
      drive(3'd4, 2'd2, 0, 0, 1, 0, 4'hF, 64'd23, 64'd3, 0, 0);
      expect_out("R5 sra64 round", 64'd3, 4'b0000);
   endtask

   task automatic t_mac();
      drive(3'd5, 2'd1, 1, 1, 0, 0, 4'hF, 64'h1234_0100_5678_FFFE, 64'hABCD_0100_9999_0003, 0,
            64'h7FFF_FFF0_0000_0010);
      expect_out("R6 mac32 signed sat", 64'h7FFF_FFFF_0000_000A, 4'b0010);
      drive(3'd5, 2'd0, 0, 0, 0, 0, 4'hF, 64'h00FF, 64'h00FF, 0, 64'h1);
      expect_out("R6 mac16 unsigned", 64'h0000_0000_0000_FE02, 4'b0000);
      drive(3'd5, 2'd2, 1, 0, 0, 0, 4'hF, 64'h0000_0000_FFFF_FFFF, 64'h5, 0, 64'd10);
      expect_out("R6 mac64 signed", 64'd5, 4'b0000);
   endtask

   task automatic t_scalar();
      drive(3'd0, 2'd0, 0, 0, 0, 1, 4'hF, 64'h0004_0003_0002_0001, '1, 64'hFFFF_FFFF_FFFF_0010, 0);
      expect_out("R7 scalar16", 64'h0014_0013_0012_0011, 4'b0000);
      drive(3'd0, 2'd1, 0, 0, 0, 1, 4'hF, 64'h0000_0001_0000_0002, '1, 64'hFFFF_FFFF_0000_0100, 0);
      expect_out("R7 scalar32", 64'h0000_0101_0000_0102, 4'b0000);
   endtask

   task automatic t_mask();
      drive(3'd0, 2'd0, 0, 0, 0, 0, 4'b0101, 64'h0001_0001_0001_0001, 64'h0001_0001_0001_0001, 0,
            64'hAAAA_BBBB_CCCC_DDDD);
      expect_out("R8 mask16", 64'hAAAA_0002_CCCC_0002, 4'b0000);
      drive(3'd0, 2'd0, 1, 1, 0, 0, 4'b0110, 64'h7FFF_8000_0010_7000, 64'h0001_FFFF_FFF0_1000, 0,
            64'h1111_2222_3333_4444);
      expect_out("R8 mask hides sat", 64'h1111_8000_0000_4444, 4'b0100);
      drive(3'd0, 2'd1, 0, 0, 0, 0, 4'b1110, 64'h0000_0001_0000_0001, 64'h0000_0001_0000_0001, 0,
            64'h5555_5555_6666_6666);
      expect_out("R8 mask32", 64'h0000_0002_6666_6666, 4'b0000);
   endtask

   task automatic t_valid_hold();
      logic [63:0] held;
      drive(3'd0, 2'd2, 0, 0, 0, 0, 4'hF, 64'h10, 64'h20, 0, 0);
      expect_out("R9 one-cycle result", 64'h30, 4'b0000);
      held = result;
      src_a = 64'hFFFF; src_b = 64'hFFFF; old_dst = 64'h1234;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || result !== held) begin
         failures++;
         $display("FAIL R9 hold actual valid=%b result=%h expected valid=0 result=%h", out_valid, result, held);
      end
   endtask

   task automatic t_reserved();
      drive(3'd6, 2'd0, 1, 1, 0, 0, 4'hF, 64'h7FFF, 64'h7FFF, 0, 64'hDEAD_BEEF_0123_4567);
      expect_out("R10 reserved 6", 64'hDEAD_BEEF_0123_4567, 4'b0000);
      drive(3'd7, 2'd1, 0, 1, 1, 0, 4'hF, '1, '1, 0, 64'h0BAD_F00D_CAFE_0001);
      expect_out("R10 reserved 7", 64'h0BAD_F00D_CAFE_0001, 4'b0000);
   endtask

   initial begin : watchdog
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_widths();
      t_saturate();
      t_logic_shift();
      t_arith_shift();
      t_mac();
      t_scalar();
      t_mask();
      t_valid_hold();
      t_reserved();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule